// File: doc/BRIEF.md
# Prescaled 16-bit Event Timer with Compare-Trigger Clear

This block is a 16-bit up-counter for a peripheral bus with byte-wide registers. Software chooses the count source. It can be a per-cycle instruction tick, or rising edges on an external clock pin. The external pin can be resynchronised through a flop chain or taken through a single sampling flop. A prescaler of 1, 2, 4 or 8 sits in front of the counter. When the count wraps past its maximum, the block sets a sticky interrupt flag. A separate enable bit decides whether that flag drives the interrupt line.

Two compare units can each send a single-cycle trigger. A trigger from the selected unit clears the count, so the compare value acts as the timer period. That clear never raises the interrupt flag. A software write to the count in the same cycle beats the trigger. In 16-bit access mode, reading the low byte captures the high byte, and a write to the high byte is held back until the low byte is written. Software therefore sees and loads both halves as one value.

The register port is a plain strobe interface. Every access finishes in the cycle it is presented, so there is no valid/ready handshake and no back-pressure. `bus_rdata` is combinational from `bus_addr`.

Top module: `evt_timer16`

## Requirements
- R1: Each prescaled count event adds one to the 16-bit count, which runs from 0x0000 to 0xFFFF and then wraps to 0x0000. The low byte is at address 0 and the high byte at address 1.
- R2: Control bits [5:4] set the prescale ratio: 0 gives 1, 1 gives 2, 2 gives 4 and 3 gives 8. The prescaler restarts from zero whenever either count byte is written. Writing the control register (address 2) does not restart it.
- R3: A wrap from 0xFFFF sets the interrupt flag, bit 0 of address 3. Writing 0 to that bit clears the flag and writing 1 has no effect. If a wrap and a clearing write happen in the same cycle, the flag ends up set.
- R4: `irq` is high exactly when the flag is set and the enable bit (bit 1 of address 3, read/write) is set.
- R5: An accepted compare trigger sets the count to 0x0000 without setting the flag. It takes priority over an increment in the same cycle.
- R6: A count-byte write in the same cycle as an accepted trigger loads the written byte and suppresses the clear. The other byte keeps its value.
- R7: The trigger source is chosen by control bits {6,3}: 00 accepts no trigger, 01 accepts `evt_trig[0]`, 10 accepts `evt_trig[1]`, and 11 accepts either.
- R8: Triggers are accepted with the internal source, or with the external source when it is synchronised. They are ignored when control bit 1 = 1 and control bit 2 = 1.
- R9: With control bit 1 = 1, the timer counts rising edges of `ext_clk`. Bit 2 = 0 sends the pin through the synchroniser chain and bit 2 = 1 sends it through a single flop. When bit 1 = 0, `tick_in` pulses are counted instead.
- R10: With control bit 0 = 0, both the count and the prescaler hold their values, while register reads and writes still work.
- R11: With control bit 7 = 1, reading address 0 captures the high byte, and address 1 then reads that captured copy. A write to address 1 is buffered and reaches the count together with the next write to address 0. With bit 7 = 0, both bytes are accessed directly.
- R12: Reset clears the control register, the flag and the enable bit. It leaves the count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_in | input | 1 | Internal count tick, one pulse per instruction cycle |
| ext_clk | input | 1 | External clock or oscillator level |
| evt_trig | input | 2 | Single-cycle special-event pulses from two compare units |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe (drives the 16-bit capture) |
| bus_addr | input | 2 | Register address: 0 count low, 1 count high, 2 control, 3 interrupt |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| irq | output | 1 | Interrupt request |

## Verification
A table of start values, prescale ratios and tick counts drives the counting path. It separates correct division from off-by-one prescaler alignment, and a carry from the low byte into the high byte from a wrap at 0xFFFF, both with and without a flag. Directed cases put a trigger in the same cycle as a tick at 0xFFFF, a low-byte write or a timer-off state. They walk all four trigger-select codes, and they compare synchronised and single-flop external counting. Each case shows whether a priority or a gating rule is ordered the right way. A further sequence with captured reads and buffered writes tells coherent 16-bit access apart from direct byte access, and a mid-run reset shows that the count survives while the control state is cleared.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 2 * BYTE_W;

  typedef struct packed {
    logic       rw16;
    logic       trg_hi;
    logic [1:0] div_sel;
    logic       trg_lo;
    logic       nosync;
    logic       ext_sel;
    logic       run;
  } tmr_ctrl_t;

  typedef enum logic [1:0] {
    A_CNT_LO = 2'd0,
    A_CNT_HI = 2'd1,
    A_CTRL   = 2'd2,
    A_IRQ    = 2'd3
  } tmr_addr_e;
endpackage

// File: rtl/tmr_src_sel.sv
module tmr_src_sel #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_in,
  input  logic ext_clk,
  input  logic ext_sel,
  input  logic nosync,
  output logic src_evt
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic sync_prev;
  logic raw_prev;
  logic sync_edge;
  logic raw_edge;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q    <= '0;
      sync_prev <= 1'b0;
      raw_prev  <= 1'b0;
    end else begin
      sync_q[0] <= ext_clk;
      for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
      sync_prev <= sync_q[SYNC_STAGES-1];
      raw_prev  <= sync_q[0];
    end
  end

  assign sync_edge = sync_q[SYNC_STAGES-1] & ~sync_prev;
  assign raw_edge  = sync_q[0] & ~raw_prev;

  always_comb begin
    if (!ext_sel)     src_evt = tick_in;
    else if (nosync)  src_evt = raw_edge;
    else              src_evt = sync_edge;
  end
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             src_evt,
  input  logic             run,
  input  logic             clr,
  input  logic [SEL_W-1:0] div_sel,
  output logic             inc
);
  localparam int PS_W = (1 << SEL_W) - 1;

  logic [PS_W-1:0] pcnt;
  logic [PS_W-1:0] mask;
  logic            hit;

  always_comb begin
    for (int i = 0; i < PS_W; i++) mask[i] = (i < int'(div_sel));
  end

  assign hit = ((pcnt & mask) == mask);
  assign inc = src_evt & run & hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               pcnt <= '0;
    else if (clr)             pcnt <= '0;
    else if (src_evt && run)  pcnt <= hit ? '0 : pcnt + PS_W'(1);
  end

  // R2
  div1_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (div_sel == '0 && src_evt && run) |-> inc);

  // R10
  ps_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !clr) |=> $stable(pcnt));
endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core
  import evt_timer_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inc,
  input  logic              clr_req,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [BYTE_W-1:0] lo_val,
  input  logic [BYTE_W-1:0] hi_val,
  input  logic              flag_clr,
  output logic [CNT_W-1:0]  count_q,
  output logic              flag_q
);
  logic wr_any;
  logic wrap;

  assign wr_any = wr_lo | wr_hi;
  assign wrap   = inc & ~clr_req & ~wr_any & (count_q == '1);

  // Count survives reset by design: no reset term.
  always_ff @(posedge clk) begin
    if (wr_any) begin
      if (wr_lo) count_q[BYTE_W-1:0]     <= lo_val;
      if (wr_hi) count_q[CNT_W-1:BYTE_W] <= hi_val;
    end else if (clr_req) begin
      count_q <= '0;
    end else if (inc) begin
      count_q <= count_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flag_q <= 1'b0;
    else if (wrap)     flag_q <= 1'b1;
    else if (flag_clr) flag_q <= 1'b0;
  end

  // R5
  trig_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && !wr_any) |=> (count_q == '0));

  // R5
  trig_noflag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && !flag_q) |=> !flag_q);

  // R6
  wr_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lo && clr_req) |=> (count_q[BYTE_W-1:0] == $past(lo_val)));

  // R3
  flag_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> (count_q == '0));

  // R3
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !flag_clr) |=> flag_q);

  // R10
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc && !clr_req && !wr_any) |=> $stable(count_q));
endmodule

// File: rtl/tmr_regif.sv
module tmr_regif
  import evt_timer_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [1:0]        bus_addr,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  input  logic [CNT_W-1:0]  count_q,
  input  logic              flag_q,
  output tmr_ctrl_t         ctrl_q,
  output logic              irq_en,
  output logic              cnt_wr_lo,
  output logic              cnt_wr_hi,
  output logic [BYTE_W-1:0] lo_val,
  output logic [BYTE_W-1:0] hi_val,
  output logic              flag_clr
);
  logic [BYTE_W-1:0] hi_wbuf;
  logic [BYTE_W-1:0] hi_rbuf;
  logic we_lo, we_hi, we_ctrl, we_irq;

  assign we_lo   = bus_we && (bus_addr == A_CNT_LO);
  assign we_hi   = bus_we && (bus_addr == A_CNT_HI);
  assign we_ctrl = bus_we && (bus_addr == A_CTRL);
  assign we_irq  = bus_we && (bus_addr == A_IRQ);

  assign cnt_wr_lo = we_lo;
  assign cnt_wr_hi = ctrl_q.rw16 ? we_lo : we_hi;
  assign lo_val    = bus_wdata;
  assign hi_val    = ctrl_q.rw16 ? hi_wbuf : bus_wdata;
  assign flag_clr  = we_irq && !bus_wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      irq_en  <= 1'b0;
      hi_wbuf <= '0;
      hi_rbuf <= '0;
    end else begin
      if (we_ctrl) ctrl_q <= tmr_ctrl_t'(bus_wdata);
      if (we_irq)  irq_en <= bus_wdata[1];
      if (we_hi && ctrl_q.rw16) hi_wbuf <= bus_wdata;
      if (bus_re && bus_addr == A_CNT_LO && ctrl_q.rw16)
        hi_rbuf <= count_q[CNT_W-1:BYTE_W];
    end
  end

  always_comb begin
    unique case (bus_addr)
      A_CNT_LO: bus_rdata = count_q[BYTE_W-1:0];
      A_CNT_HI: bus_rdata = ctrl_q.rw16 ? hi_rbuf : count_q[CNT_W-1:BYTE_W];
      A_CTRL:   bus_rdata = ctrl_q;
      default:  bus_rdata = {{(BYTE_W-2){1'b0}}, irq_en, flag_q};
    endcase
  end

  // R11
  hi_buffered_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we_hi && ctrl_q.rw16 && !we_lo) |=> $stable(count_q[CNT_W-1:BYTE_W]) || $past(count_q != '0));
endmodule

// File: rtl/evt_timer16.sv
module evt_timer16
  import evt_timer_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int PS_SEL_W    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_in,
  input  logic              ext_clk,
  input  logic [1:0]        evt_trig,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [1:0]        bus_addr,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  output logic              irq
);
  tmr_ctrl_t         ctrl_q;
  logic              irq_en;
  logic              cnt_wr_lo, cnt_wr_hi, flag_clr;
  logic [BYTE_W-1:0] lo_val, hi_val;
  logic [CNT_W-1:0]  count_q;
  logic              flag_q;
  logic              src_evt, inc;
  logic              trig_hit, trig_ok, clr_req;

  tmr_regif u_regif (
    .clk, .rst_n, .bus_we, .bus_re, .bus_addr, .bus_wdata, .bus_rdata,
    .count_q, .flag_q, .ctrl_q, .irq_en, .cnt_wr_lo, .cnt_wr_hi,
    .lo_val, .hi_val, .flag_clr
  );

  tmr_src_sel #(.SYNC_STAGES(SYNC_STAGES)) u_src (
    .clk, .rst_n, .tick_in, .ext_clk,
    .ext_sel(ctrl_q.ext_sel), .nosync(ctrl_q.nosync), .src_evt
  );

  tmr_prescaler #(.SEL_W(PS_SEL_W)) u_ps (
    .clk, .rst_n, .src_evt, .run(ctrl_q.run),
    .clr(cnt_wr_lo | cnt_wr_hi), .div_sel(ctrl_q.div_sel[PS_SEL_W-1:0]), .inc
  );

  assign trig_hit = (ctrl_q.trg_lo & evt_trig[0]) | (ctrl_q.trg_hi & evt_trig[1]);
  assign trig_ok  = ~(ctrl_q.ext_sel & ctrl_q.nosync);
  assign clr_req  = trig_hit & trig_ok;

  tmr_count_core u_core (
    .clk, .rst_n, .inc, .clr_req, .wr_lo(cnt_wr_lo), .wr_hi(cnt_wr_hi),
    .lo_val, .hi_val, .flag_clr, .count_q, .flag_q
  );

  assign irq = flag_q & irq_en;

  // R8
  async_ign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q.ext_sel && ctrl_q.nosync && !inc && !cnt_wr_lo && !cnt_wr_hi) |=> $stable(count_q));
endmodule

// File: tb/tb_evt_timer16.sv
module tb_evt_timer16;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_in = 1'b0;
  logic       ext_clk = 1'b0;
  logic [1:0] evt_trig = 2'b00;
  logic       bus_we = 1'b0;
  logic       bus_re = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic       irq;

  int errors = 0;
  int checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  evt_timer16 dut (
    .clk, .rst_n, .tick_in, .ext_clk, .evt_trig, .bus_we, .bus_re,
    .bus_addr, .bus_wdata, .bus_rdata, .irq
  );

  // {div_sel[2], ticks[8], start[16], expected[16], flag[1]}
  localparam int NV = 8;
  localparam logic [42:0] VEC [NV] = '{
    {2'd0, 8'd5,  16'h0000, 16'h0005, 1'b0},
    {2'd1, 8'd7,  16'h0010, 16'h0013, 1'b0},
    {2'd2, 8'd9,  16'h00FF, 16'h0101, 1'b0},
    {2'd3, 8'd16, 16'h1234, 16'h1236, 1'b0},
    {2'd0, 8'd3,  16'hFFFE, 16'h0001, 1'b1},
    {2'd1, 8'd4,  16'hFFFF, 16'h0001, 1'b1},
    {2'd0, 8'd1,  16'hFFFF, 16'h0000, 1'b1},
    {2'd3, 8'd7,  16'hFFFF, 16'hFFFF, 1'b0}
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_re = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_re = 1'b0;
  endtask

  task automatic rd16(output logic [15:0] v);
    logic [7:0] lo, hi;
    rd(2'd0, lo);
    rd(2'd1, hi);
    v = {hi, lo};
  endtask

  task automatic set_cnt(input logic [15:0] v);
    wr(2'd1, v[15:8]);
    wr(2'd0, v[7:0]);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_in = 1'b1;
      @(negedge clk); tick_in = 1'b0;
    end
  endtask

  task automatic trig(input logic [1:0] t);
    @(negedge clk); evt_trig = t;
    @(negedge clk); evt_trig = 2'b00;
  endtask

  task automatic ext_pulses(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); ext_clk = 1'b1;
      repeat (4) @(negedge clk);
      ext_clk = 1'b0;
      repeat (4) @(negedge clk);
    end
    repeat (4) @(negedge clk);
  endtask

  logic done = 1'b0;

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    logic [7:0]  b;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R12 reset state
    rd(2'd2, b); chk("R12 ctrl after reset", {8'h0, b}, 16'h0000);
    rd(2'd3, b); chk("R12 irq reg after reset", {8'h0, b}, 16'h0000);
    #1 chk("R4 irq low after reset", {15'd0, irq}, 16'd0);

    // R1 R2 R3 vector table
    for (int k = 0; k < NV; k++) begin
      logic [42:0] e;
      e = VEC[k];
      wr(2'd2, {2'b00, e[42:41], 4'b0001});
      set_cnt(e[32:17]);
      wr(2'd3, 8'h00);
      ticks(int'(e[40:33]));
      rd16(v);
      chk($sformatf("R1/R2 vector %0d count", k), v, e[16:1]);
      rd(2'd3, b);
      chk($sformatf("R3 vector %0d flag", k), {15'd0, b[0]}, {15'd0, e[0]});
    end

    // R5 trigger clears without flag
    wr(2'd2, 8'h09);
    set_cnt(16'hFFF0);
    wr(2'd3, 8'h00);
    trig(2'b01);
    rd16(v); chk("R5 trigger clears count", v, 16'h0000);
    rd(2'd3, b); chk("R5 trigger leaves flag clear", {8'h0, b}, 16'h0000);
    // R5 trigger beats increment at 0xFFFF
    set_cnt(16'hFFFF);
    @(negedge clk); tick_in = 1'b1; evt_trig = 2'b01;
    @(negedge clk); tick_in = 1'b0; evt_trig = 2'b00;
    rd16(v); chk("R5 trigger over wrap count", v, 16'h0000);
    rd(2'd3, b); chk("R5 trigger over wrap flag", {8'h0, b}, 16'h0000);

    // R6 write wins over trigger
    set_cnt(16'h1200);
    @(negedge clk); bus_we = 1'b1; bus_addr = 2'd0; bus_wdata = 8'h55; evt_trig = 2'b01;
    @(negedge clk); bus_we = 1'b0; evt_trig = 2'b00;
    rd16(v); chk("R6 write beats trigger", v, 16'h1255);

    // R7 trigger select
    wr(2'd2, 8'h01);
    set_cnt(16'h0321);
    trig(2'b11);
    rd16(v); chk("R7 select 00 ignores both", v, 16'h0321);
    wr(2'd2, 8'h41);
    trig(2'b01);
    rd16(v); chk("R7 select 10 ignores unit0", v, 16'h0321);
    trig(2'b10);
    rd16(v); chk("R7 select 10 takes unit1", v, 16'h0000);
    wr(2'd2, 8'h49);
    set_cnt(16'h0321);
    trig(2'b10);
    rd16(v); chk("R7 select 11 takes unit1", v, 16'h0000);

    // R8 trigger accepted in synced external, ignored in async
    wr(2'd2, 8'h0B);
    set_cnt(16'h0777);
    trig(2'b01);
    rd16(v); chk("R8 synced external trigger", v, 16'h0000);
    wr(2'd2, 8'h0F);
    set_cnt(16'h0777);
    trig(2'b01);
    rd16(v); chk("R8 async trigger ignored", v, 16'h0777);

    // R9 external counting, both paths
    wr(2'd2, 8'h03);
    set_cnt(16'h0000);
    ticks(2);
    ext_pulses(3);
    rd16(v); chk("R9 synced external edges", v, 16'h0003);
    wr(2'd2, 8'h07);
    set_cnt(16'h0000);
    ext_pulses(3);
    rd16(v); chk("R9 single-flop external edges", v, 16'h0003);

    // R10 off freezes count and prescaler
    wr(2'd2, 8'h00);
    set_cnt(16'h0042);
    ticks(5);
    rd16(v); chk("R10 off holds count", v, 16'h0042);
    wr(2'd2, 8'h11);
    set_cnt(16'h0000);
    ticks(1);
    wr(2'd2, 8'h10);
    ticks(3);
    wr(2'd2, 8'h11);
    ticks(1);
    rd16(v); chk("R10 off holds prescaler", v, 16'h0001);

    // R3 R4 overflow vs clearing write, and enable gating
    wr(2'd2, 8'h01);
    set_cnt(16'hFFFF);
    wr(2'd3, 8'h00);
    @(negedge clk); tick_in = 1'b1; bus_we = 1'b1; bus_addr = 2'd3; bus_wdata = 8'h02;
    @(negedge clk); tick_in = 1'b0; bus_we = 1'b0;
    rd(2'd3, b); chk("R3 wrap beats clear", {8'h0, b}, 16'h0003);
    #1 chk("R4 irq with flag and enable", {15'd0, irq}, 16'd1);
    wr(2'd3, 8'h01);
    rd(2'd3, b); chk("R3 writing one keeps flag", {8'h0, b}, 16'h0001);
    #1 chk("R4 irq masked by enable", {15'd0, irq}, 16'd0);
    wr(2'd3, 8'h00);
    rd(2'd3, b); chk("R3 writing zero clears flag", {8'h0, b}, 16'h0000);

    // R11 16-bit coherent access
    wr(2'd2, 8'h81);
    wr(2'd1, 8'h00);
    wr(2'd0, 8'hFF);
    rd(2'd0, b); chk("R11 low read", {8'h0, b}, 16'h00FF);
    ticks(1);
    rd(2'd1, b); chk("R11 high read returns capture", {8'h0, b}, 16'h0000);
    wr(2'd2, 8'h80);
    wr(2'd1, 8'h77);
    rd16(v); chk("R11 high write buffered", v, 16'h0100);
    wr(2'd0, 8'h11);
    rd16(v); chk("R11 paired write lands", v, 16'h7711);
    wr(2'd2, 8'h00);
    rd(2'd1, b); chk("R11 direct high read", {8'h0, b}, 16'h0077);

    // R12 reset keeps count, clears control
    set_cnt(16'hABCD);
    wr(2'd2, 8'h81);
    wr(2'd3, 8'h02);
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk); rst_n = 1'b1;
    rd(2'd2, b); chk("R12 ctrl cleared", {8'h0, b}, 16'h0000);
    rd(2'd3, b); chk("R12 irq reg cleared", {8'h0, b}, 16'h0000);
    rd16(v); chk("R12 count kept", v, 16'hABCD);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule